// File: doc/BRIEF.md
# Memory Integrity Check Sequencer

This controller walks every word of an attached read-only memory array, reads each one through a synchronous read port and folds the returned words into a 32-bit multiple-input signature register (MISR). When the walk is over, software compares the signature with a value it already knows. A small 8-bit control/status register starts the walk and reports when it is done. The same register selects the address order, turns on margin reads at a chosen level and turns on the ECC check.

The array is split into equal blocks. The upper address bits are the block index. A block is read only if its bit in the select mask is 1 and its bit in the lock mask is 0. The controller does not start while any erase, program or high-voltage activity is reported. It also refuses margin reads unless the address order is plain ascending.

The margin and ECC mode outputs are raised only while a check runs. Ordinary accesses to the array outside a check therefore never see them.

Top module: `integ_scan`

## Requirements
- R1: After reset the done flag is 1, every configuration field and the error bit are 0, the signature is 0 and no read is issued. The register reads back 0x02.
- R2: Register layout:
  - bit 0: write-1 start
  - bit 1: done, read-only
  - bit 2: order select
  - bit 3: margin enable
  - bit 4: margin level
  - bit 5: ECC-check enable
  - bit 6: error, read-only

  A start write is ignored as a whole while the done flag is 0 or while any of `ers_busy`, `pgm_busy` or `hv_busy` is high.
- R3: An accepted start clears the done flag on the same clock edge. The flag stays 0 while the check runs. It returns to 1 only after the last returned word has been folded into the signature, and the signature is final at that point.
- R4: A check reads every address whose block (address divided by the words per block) is selected and not locked, exactly once. It reads no other address.
- R5: With order select = 1 the addresses ascend. With order select = 0 all even addresses are read in ascending order, then all odd addresses in ascending order.
- R6: The signature is cleared to 0 when a check starts. For each returned word d it becomes (sig << 1) XOR (sig[31] ? 0x00400007 : 0) XOR d.
- R7: A start request with margin enable 1 and order select 0 is rejected. It changes no field and starts nothing, and it sets the error bit. An accepted start clears the error bit.
- R8: `mem_margin` equals margin enable, `mem_mlvl` equals margin enable AND margin level, and `ecc_chk` equals ECC-check enable, but only while a check runs. Outside a check all three are 0, whatever the fields hold.
- R9: Bits 2 to 5 accept writes only while the done flag and `glb_done` are both 1. Otherwise writes to them are ignored and they read back as 0.
- R10: If no block is both selected and unlocked, an accepted start leaves the done flag at 1, clears the signature and issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data, registered |
| glb_done | input | 1 | Global done; while it is 0 the test fields are hidden and frozen |
| ers_busy | input | 1 | Erase in progress |
| pgm_busy | input | 1 | Program in progress |
| hv_busy | input | 1 | High voltage enabled |
| blk_sel | input | 2**BLK_W | Per-block select mask |
| blk_lock | input | 2**BLK_W | Per-block lock mask |
| mem_addr | output | BLK_W+BLK_AW | Array word address |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` one cycle later |
| mem_rdata | input | DATA_W | Returned array word |
| mem_margin | output | 1 | Margin read active |
| mem_mlvl | output | 1 | Margin level: 1 = erased level, 0 = programmed level |
| ecc_chk | output | 1 | ECC check active |
| scan_done | output | 1 | Done flag |
| sig | output | DATA_W | Signature register |

## Verification
The hardest state to reach from the ports is a check already in flight that then receives a write to the test fields. The done flag must be 0 for exactly that write, so the bench issues it while a full-array ascending walk of 32 reads is still running. It then reads the fields back after done has returned.

Block eligibility and address order are covered by a sweep over every select mask, two lock masks and both orders. In each run the bench records every strobed address and compares the list with an order and a signature it builds arithmetically. The sweep also passes through the empty-eligibility case with a nonzero signature left over from the previous run, which shows that the signature really is cleared.

// File: rtl/integ_pkg.sv
package integ_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } scan_st_e;

  // test fields, packed so they map straight onto register bits 5..2
  typedef struct packed {
    logic ecc;
    logic lvl;
    logic mrg;
    logic seq;
  } tcfg_t;

  localparam int CSR_W   = 8;
  localparam int B_GO    = 0;
  localparam int B_DONE  = 1;
  localparam int B_CFG   = 2;
  localparam int B_ERR   = 6;

endpackage

// File: rtl/integ_csr.sv
module integ_csr
  import integ_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  input  logic             glb_done,
  input  logic             done,
  input  logic             busy_any,
  output logic             start_ok,
  output tcfg_t            cfg_q,
  output tcfg_t            cfg_d,
  output logic             err_q,
  output logic [CSR_W-1:0] rdata
);

  logic  wr_ok;
  logic  go;
  logic  bad;
  logic  err_d;
  tcfg_t cfg_eff;
  logic  unused_bits;

  assign unused_bits = ^{wdata[CSR_W-1:B_ERR], wdata[B_DONE]};

  always_comb begin
    wr_ok    = done & glb_done;
    cfg_eff  = wr_ok ? tcfg_t'(wdata[B_CFG +: 4]) : cfg_q;
    go       = we & wdata[B_GO] & done & ~busy_any;
    bad      = cfg_eff.mrg & ~cfg_eff.seq;
    start_ok = go & ~bad;
    cfg_d    = cfg_q;
    if (we && !wdata[B_GO] && wr_ok) cfg_d = cfg_eff;
    if (start_ok)                    cfg_d = cfg_eff;
    err_d = err_q;
    if (go && bad)     err_d = 1'b1;
    else if (start_ok) err_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      err_q <= 1'b0;
      rdata <= CSR_W'(1) << B_DONE;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
      rdata <= {1'b0, err_q, (wr_ok ? cfg_q : tcfg_t'('0)), done, 1'b0};
    end
  end

  AST_CFG_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> $past(done && glb_done)); // R9

  AST_ERR_KEEPS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> done); // R7

endmodule

// File: rtl/integ_addr_gen.sv
module integ_addr_gen #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          seq,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [AW-1:0] idx;
  logic [AW-1:0] alt;

  always_ff @(posedge clk) begin
    if (rst || clr)  idx <= '0;
    else if (step)   idx <= idx + 1'b1;
  end

  // even words first, then odd: rotate the index left by one
  generate
    if (AW > 1) begin : g_rot
      assign alt = {idx[AW-2:0], idx[AW-1]};
    end else begin : g_flat
      assign alt = idx;
    end
  endgenerate

  always_comb begin
    addr = seq ? idx : alt;
    last = &idx;
  end

  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!step && !$past(clr)) |=> $stable(idx) || $past(clr)); // R4

endmodule

// File: rtl/integ_misr.sv
module integ_misr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h0040_0007
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed,
  input  logic         fold,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);

  logic [W-1:0] sig_n;

  always_comb begin
    sig_n = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0) ^ din;
  end

  always_ff @(posedge clk) begin
    if (rst || seed) sig <= '0;
    else if (fold)   sig <= sig_n;
  end

  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!seed && !fold) |=> $stable(sig)); // R6

endmodule

// File: rtl/integ_scan.sv
module integ_scan
  import integ_pkg::*;
#(
  parameter int                BLK_W  = 2,
  parameter int                BLK_AW = 3,
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] POLY   = 32'h0040_0007
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    csr_we,
  input  logic [7:0]              csr_wdata,
  output logic [7:0]              csr_rdata,
  input  logic                    glb_done,
  input  logic                    ers_busy,
  input  logic                    pgm_busy,
  input  logic                    hv_busy,
  input  logic [(1<<BLK_W)-1:0]   blk_sel,
  input  logic [(1<<BLK_W)-1:0]   blk_lock,
  output logic [BLK_W+BLK_AW-1:0] mem_addr,
  output logic                    mem_rd,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    mem_margin,
  output logic                    mem_mlvl,
  output logic                    ecc_chk,
  output logic                    scan_done,
  output logic [DATA_W-1:0]       sig
);

  localparam int AW   = BLK_W + BLK_AW;
  localparam int NBLK = 1 << BLK_W;

  scan_st_e        state, state_n;
  logic            done_q;
  logic            rd_d1;
  logic [NBLK-1:0] elig_q;
  logic            any_elig;
  logic            start_ok;
  logic            err_q;
  tcfg_t           cfg_q, cfg_d;
  logic [AW-1:0]   gen_addr;
  logic            gen_last;
  logic            run_n;

  assign scan_done = done_q;
  assign any_elig  = |(blk_sel & ~blk_lock);

  integ_csr u_csr (
    .clk      (clk),
    .rst      (rst),
    .we       (csr_we),
    .wdata    (csr_wdata),
    .glb_done (glb_done),
    .done     (done_q),
    .busy_any (ers_busy | pgm_busy | hv_busy),
    .start_ok (start_ok),
    .cfg_q    (cfg_q),
    .cfg_d    (cfg_d),
    .err_q    (err_q),
    .rdata    (csr_rdata)
  );

  integ_addr_gen #(.AW(AW)) u_agen (
    .clk  (clk),
    .rst  (rst),
    .clr  (start_ok),
    .step (state == ST_SCAN),
    .seq  (cfg_q.seq),
    .addr (gen_addr),
    .last (gen_last)
  );

  integ_misr #(.W(DATA_W), .POLY(POLY)) u_misr (
    .clk  (clk),
    .rst  (rst),
    .seed (start_ok),
    .fold (rd_d1),
    .din  (mem_rdata),
    .sig  (sig)
  );

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:  if (start_ok && any_elig) state_n = ST_SCAN;
      ST_SCAN:  if (gen_last)             state_n = ST_DRAIN;
      ST_DRAIN: if (!mem_rd && !rd_d1)    state_n = ST_IDLE;
      default:                            state_n = ST_IDLE;
    endcase
    run_n = (state_n != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      done_q     <= 1'b1;
      rd_d1      <= 1'b0;
      elig_q     <= '0;
      mem_rd     <= 1'b0;
      mem_addr   <= '0;
      mem_margin <= 1'b0;
      mem_mlvl   <= 1'b0;
      ecc_chk    <= 1'b0;
    end else begin
      state <= state_n;
      rd_d1 <= mem_rd;
      if (start_ok) elig_q <= blk_sel & ~blk_lock;
      if (start_ok && any_elig)
        done_q <= 1'b0;
      else if (state == ST_DRAIN && state_n == ST_IDLE)
        done_q <= 1'b1;
      mem_rd <= (state == ST_SCAN) && elig_q[gen_addr[AW-1 -: BLK_W]];
      if (state == ST_SCAN) mem_addr <= gen_addr;
      mem_margin <= run_n & cfg_d.mrg;
      mem_mlvl   <= run_n & cfg_d.mrg & cfg_d.lvl;
      ecc_chk    <= run_n & cfg_d.ecc;
    end
  end

  AST_START_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(done_q) |-> $past(!ers_busy && !pgm_busy && !hv_busy)); // R2

  AST_RD_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !done_q); // R3

  AST_RD_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> elig_q[mem_addr[AW-1 -: BLK_W]]); // R4

  AST_MARGIN_SEQ: assert property (@(posedge clk) disable iff (rst)
    mem_margin |-> cfg_q.seq); // R7

  AST_MODE_IN_CHECK: assert property (@(posedge clk) disable iff (rst)
    (mem_margin || ecc_chk) |-> !done_q); // R8

  AST_LVL_NEEDS_MARGIN: assert property (@(posedge clk) disable iff (rst)
    mem_mlvl |-> mem_margin); // R8

  AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (start_ok && !any_elig) |=> done_q); // R10

endmodule

// File: tb/integ_scan_bench.sv
module integ_scan_bench;

  localparam int          N    = 32;
  localparam logic [31:0] POLY = 32'h0040_0007;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_rdata;
  logic        glb_done = 1'b1;
  logic        ers_busy = 1'b0, pgm_busy = 1'b0, hv_busy = 1'b0;
  logic [3:0]  blk_sel = '0, blk_lock = '0;
  logic [4:0]  mem_addr;
  logic        mem_rd;
  logic [31:0] mem_rdata = '0;
  logic        mem_margin, mem_mlvl, ecc_chk, scan_done;
  logic [31:0] sig;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [4:0] log_a [64];
  int  nrd = 0;
  int  mode_bad = 0;
  logic exp_m = 0, exp_l = 0, exp_e = 0;

  always #10 clk = ~clk;

  integ_scan u_integ_scan (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .glb_done(glb_done), .ers_busy(ers_busy),
    .pgm_busy(pgm_busy), .hv_busy(hv_busy), .blk_sel(blk_sel),
    .blk_lock(blk_lock), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_margin(mem_margin), .mem_mlvl(mem_mlvl),
    .ecc_chk(ecc_chk), .scan_done(scan_done), .sig(sig)
  );

  function automatic logic [31:0] data_of(input logic [4:0] a);
    logic [31:0] x;
    x = {27'h0, a};
    return (x * 32'h9E37_79B1) ^ 32'h3C5A_96E1 ^ {a, 27'h0};
  endfunction

  function automatic logic [31:0] step_sig(input logic [31:0] s, input logic [31:0] d);
    return (s << 1) ^ (s[31] ? POLY : 32'h0) ^ d;
  endfunction

  // synchronous array model: one cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= data_of(mem_addr);

  always @(negedge clk) begin
    if (mem_rd) begin
      if (nrd < 64) log_a[nrd] = mem_addr;
      nrd = nrd + 1;
      if (mem_margin !== exp_m || mem_mlvl !== exp_l || ecc_chk !== exp_e)
        mode_bad = mode_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk);
    csr_we = 1'b1;
    csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
    csr_wdata = '0;
  endtask

  task automatic do_scan(input bit sq, input logic [3:0] sel, input logic [3:0] lock,
                         input bit mrg, input bit lvl, input bit ecc);
    logic [3:0]  el;
    logic [31:0] es;
    int k;
    int ordbad;
    logic [4:0] a;
    blk_sel = sel;
    blk_lock = lock;
    nrd = 0;
    mode_bad = 0;
    el = sel & ~lock;
    csr_write({2'b00, ecc, lvl, mrg, sq, 1'b0, 1'b1});
    if (el != 0) chk(scan_done == 1'b0, "R3 done clears", {31'h0, scan_done}, 32'h0);
    else         chk(scan_done == 1'b1, "R10 empty stays done", {31'h0, scan_done}, 32'h1);
    for (int t = 0; t < 200 && !scan_done; t++) @(negedge clk);
    chk(scan_done == 1'b1, "R3 done sets", {31'h0, scan_done}, 32'h1);
    es = 32'h0;
    k = 0;
    ordbad = 0;
    for (int i = 0; i < N; i++) begin
      a = sq ? 5'(i) : 5'(((i << 1) | (i >> 4)) & (N - 1));
      if (el[a[4:3]]) begin
        if (k < 64 && log_a[k] !== a) ordbad++;
        k++;
        es = step_sig(es, data_of(a));
      end
    end
    chk(nrd == k, "R4 read count", 32'(nrd), 32'(k));
    chk(ordbad == 0, sq ? "R5 ascending order" : "R5 even-then-odd order", 32'(ordbad), 32'h0);
    chk(sig == es, (el == 0) ? "R10 signature cleared" : "R6 signature", sig, es);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(csr_rdata == 8'h02, "R1 register reset", {24'h0, csr_rdata}, 32'h02);
    chk(sig == 32'h0, "R1 signature reset", sig, 32'h0);
    chk(mem_rd == 1'b0 && scan_done == 1'b1, "R1 idle and done",
        {30'h0, mem_rd, scan_done}, 32'h1);

    // near-exhaustive sweep of eligibility and order
    for (int sq = 0; sq < 2; sq++)
      for (int s = 0; s < 16; s++)
        for (int l = 0; l < 2; l++)
          do_scan(sq[0], 4'(s), (l == 0) ? 4'h0 : 4'h6, 1'b0, 1'b0, 1'b0);

    // R2: each busy input blocks a start
    for (int b = 0; b < 3; b++) begin
      ers_busy = (b == 0);
      pgm_busy = (b == 1);
      hv_busy  = (b == 2);
      blk_sel = 4'hF;
      blk_lock = 4'h0;
      nrd = 0;
      csr_write(8'h05);
      repeat (6) @(negedge clk);
      chk(scan_done == 1'b1 && nrd == 0, "R2 start blocked by busy", 32'(nrd), 32'h0);
    end
    ers_busy = 0; pgm_busy = 0; hv_busy = 0;

    // R7: margin with non-sequential order is rejected
    csr_write(8'h00);
    nrd = 0;
    csr_write(8'h09);
    @(negedge clk);
    chk(scan_done == 1'b1 && nrd == 0, "R7 rejected start", 32'(nrd), 32'h0);
    chk(csr_rdata == 8'h42, "R7 error set, fields kept", {24'h0, csr_rdata}, 32'h42);

    // R8: margin outputs during an accepted margin check
    for (int lv = 0; lv < 2; lv++) begin
      exp_m = 1; exp_l = lv[0]; exp_e = 1;
      do_scan(1'b1, 4'hF, 4'h0, 1'b1, lv[0], 1'b1);
      chk(mode_bad == 0, "R8 mode outputs during check", 32'(mode_bad), 32'h0);
      @(negedge clk);
      chk({mem_margin, mem_mlvl, ecc_chk} == 3'b000, "R8 mode outputs after check",
          {29'h0, mem_margin, mem_mlvl, ecc_chk}, 32'h0);
      chk(csr_rdata == (8'h2E | (8'(lv) << 4)), "R7 error cleared by accepted start",
          {24'h0, csr_rdata}, {24'h0, 8'h2E | (8'(lv) << 4)});
      exp_m = 0; exp_l = 0; exp_e = 0;
    end

    // R9: fields hidden and frozen while a check runs
    csr_write(8'h05);
    @(negedge clk);
    chk(csr_rdata[5:1] == 5'h0, "R9 fields hidden while running", {27'h0, csr_rdata[5:1]}, 32'h0);
    csr_write(8'h3C);
    for (int t = 0; t < 200 && !scan_done; t++) @(negedge clk);
    @(negedge clk);
    chk(csr_rdata == 8'h06, "R9 write during check ignored", {24'h0, csr_rdata}, 32'h06);

    // R9: global done low hides and freezes fields
    glb_done = 1'b0;
    csr_write(8'h20);
    @(negedge clk);
    chk(csr_rdata == 8'h02, "R9 fields hidden with global done low", {24'h0, csr_rdata}, 32'h02);
    glb_done = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(csr_rdata == 8'h06, "R9 fields unchanged by gated write", {24'h0, csr_rdata}, 32'h06);

    // R8: margin fields set but no check running
    nrd = 0;
    csr_write(8'h1C);
    repeat (4) @(negedge clk);
    chk({mem_margin, mem_mlvl, ecc_chk} == 3'b000 && nrd == 0, "R8 no mode outside check",
        {29'h0, mem_margin, mem_mlvl, ecc_chk}, 32'h0);
    chk(csr_rdata == 8'h1E, "R9 fields written when idle", {24'h0, csr_rdata}, 32'h1E);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule